// File: doc/BRIEF.md
# Firmware-Update Frame Command Engine

This block sits behind a message-bus receiver and carries out firmware-update commands on a small internal program store. Each incoming frame is a payload of up to eight bytes plus a byte count. The first byte selects a command: a single addressed word write, a streaming write of two words at an auto-incrementing pointer, a page-granular range erase, a CRC16 over a stored range, or a single-word read. The store holds 24-bit words at 24-bit word addresses. Words that were never written, and words that have been erased, read as all ones.

Frames enter on a valid/ready input. A frame is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` drops for the whole of an erase or checksum sweep, which handles one store word per clock. It also stays low while a reply is waiting on the output. Replies leave on a valid/ready output. Once `out_valid` rises, the reply holds steady until the consumer raises `out_ready`, and the engine accepts no further frame until that happens. The result is that back-pressure on the reply side stalls the input side.

The checksum is computed from the words read back out of the store, not from the frames that were received. A write that went astray therefore shows up in the checksum.

Top module: `fwu_cmd_engine`

## Requirements
- R1: After reset `in_ready` is 1, `out_valid` is 0, `err_flag` is 0, the auto-increment pointer is 0, and every store word reads 0xFFFFFF.
- R2: Payload byte k (k = 0 is first) is `in_data[63-8k -: 8]` and `in_len` is the count of valid bytes. Byte 0 is the mode. Bytes 1-3 are field A and bytes 4-6 are field B, each a 24-bit value sent most significant byte first. Byte 7 is ignored.
- R3: Mode 0xFF (length ≥ 7) writes the word in field B at the address in field A, then sets the pointer to A+1.
- R4: Mode 0xFE (length ≥ 7) writes field A at the pointer and field B at pointer+1, then advances the pointer by 2.
- R5: Mode 0xFB (length ≥ 4) produces, one clock after acceptance, a reply with `out_len` = 7. Its bytes are 0xFB, the three address bytes, the three bytes of the stored word, and then a zero byte. An address outside the store reads 0xFFFFFF.
- R6: Mode 0xFC (length ≥ 7, A ≤ B) sets to 0xFFFFFF every word from the page base of A through the last word of the page that holds B. The result is clipped to the store. A page is PAGE_WORDS words and is aligned to a multiple of PAGE_WORDS. `in_ready` stays low for exactly one clock per clipped word, or for no clock if the range lies entirely beyond the store.
- R7: Mode 0xFD (length ≥ 7, A ≤ B) replies with `out_len` = 3 and the bytes 0xFD, CRC high byte, CRC low byte. The CRC is CRC16 with polynomial 0x1021 and initial value 0xFFFF, processed MSB first. It covers the stored words from A through B inclusive, each word fed as three bytes starting with the most significant. The reply appears after B-A+1 sweep clocks.
- R8: A raised `out_valid` stays high with `out_data`/`out_len` unchanged until a clock edge with `out_ready` high clears it. `in_ready` is low whenever `out_valid` is high.
- R9: A frame with an unknown mode, with fewer bytes than its mode needs, or a 0xFC/0xFD frame with B < A, is dropped. It changes neither the store nor the pointer and produces no reply. It sets `err_flag`, which stays set until reset.
- R10: A 0xFF/0xFE word write whose address lies at or beyond STORE_WORDS is not performed and sets `err_flag`. The pointer still updates as in R3/R4, and an in-range partner word is still written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Frame offered |
| in_ready | output | 1 | Engine can take a frame this cycle |
| in_data | input | 64 | Payload bytes, first byte in bits 63:56 |
| in_len | input | 4 | Number of valid payload bytes |
| out_valid | output | 1 | Reply frame pending |
| out_ready | input | 1 | Consumer takes the reply |
| out_data | output | 64 | Reply bytes, first byte in bits 63:56 |
| out_len | output | 4 | Number of valid reply bytes |
| err_flag | output | 1 | Sticky error indication |

## Verification
Directed cases target the following:
- Erase ranges that cross a page boundary, that run off the top of the store, and that start beyond it. A design that aligns or clips pages wrongly would wipe the wrong words, or would hold `in_ready` low for the wrong number of clocks.
- Streaming writes after an out-of-range addressed write. A pointer that fails to advance, or that advances by one, would put words at the wrong addresses.
- A held-back reply. A design that dropped or changed a reply under back-pressure, or that accepted a frame while the reply was pending, would lose data.

Random mixes of writes, reads, bad frames, sweeps and checksums run against a reference store in the bench. Checksums taken after erases and writes expose a CRC computed over received data instead of stored data, as well as errors in byte order or in the initial value.

// File: rtl/fwu_pkg.sv
package fwu_pkg;

  localparam logic [7:0] MODE_WRITE  = 8'hFF;
  localparam logic [7:0] MODE_STREAM = 8'hFE;
  localparam logic [7:0] MODE_CRC    = 8'hFD;
  localparam logic [7:0] MODE_ERASE  = 8'hFC;
  localparam logic [7:0] MODE_READ   = 8'hFB;

  localparam logic [23:0] ERASED_WORD = 24'hFFFFFF;
  localparam logic [15:0] CRC_SEED    = 16'hFFFF;
  localparam logic [15:0] CRC_POLY    = 16'h1021;

  typedef enum logic [2:0] {
    OP_NONE, OP_WRITE, OP_STREAM, OP_CRC, OP_ERASE, OP_READ
  } op_e;

  typedef struct packed {
    op_e         op;
    logic        bad;
    logic [7:0]  mode;
    logic [23:0] fa;
    logic [23:0] fb;
  } cmd_t;

  function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[15] ^ b[i]) r = {r[14:0], 1'b0} ^ CRC_POLY;
      else              r = {r[14:0], 1'b0};
    end
    return r;
  endfunction

  function automatic logic [15:0] crc_word(input logic [15:0] c, input logic [23:0] w);
    return crc_byte(crc_byte(crc_byte(c, w[23:16]), w[15:8]), w[7:0]);
  endfunction

endpackage

// File: rtl/fwu_decode.sv
module fwu_decode
  import fwu_pkg::*;
(
  input  logic [63:0] data,
  input  logic [3:0]  len,
  output cmd_t        cmd
);
  logic [3:0] need;

  always_comb begin
    cmd.mode = data[63:56];
    cmd.fa   = data[55:32];
    cmd.fb   = data[31:8];
    need     = 4'd7;
    case (cmd.mode)
      MODE_WRITE:  cmd.op = OP_WRITE;
      MODE_STREAM: cmd.op = OP_STREAM;
      MODE_CRC:    cmd.op = OP_CRC;
      MODE_ERASE:  cmd.op = OP_ERASE;
      MODE_READ: begin
        cmd.op = OP_READ;
        need   = 4'd4;
      end
      default:     cmd.op = OP_NONE;
    endcase
    cmd.bad = (cmd.op == OP_NONE) || (len < need) ||
              (((cmd.op == OP_CRC) || (cmd.op == OP_ERASE)) && (cmd.fb < cmd.fa));
  end
endmodule

// File: rtl/fwu_store.sv
module fwu_store
  import fwu_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wa_en,
  input  logic [23:0] wa_addr,
  input  logic [23:0] wa_data,
  input  logic        wb_en,
  input  logic [23:0] wb_addr,
  input  logic [23:0] wb_data,
  input  logic [23:0] rd_addr,
  output logic [23:0] rd_data
);
  localparam int          AW      = $clog2(DEPTH);
  localparam logic [23:0] DEPTH_L = 24'(DEPTH);

  logic [23:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED_WORD;
    end else begin
      if (wa_en && (wa_addr < DEPTH_L)) mem[wa_addr[AW-1:0]] <= wa_data;
      if (wb_en && (wb_addr < DEPTH_L)) mem[wb_addr[AW-1:0]] <= wb_data;
    end
  end

  assign rd_data = (rd_addr < DEPTH_L) ? mem[rd_addr[AW-1:0]] : ERASED_WORD;
endmodule

// File: rtl/fwu_sweep.sv
module fwu_sweep
  import fwu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        crc_mode,
  input  logic [23:0] lo,
  input  logic [23:0] hi,
  input  logic [23:0] rdata,
  output logic        busy,
  output logic        last,
  output logic [23:0] addr,
  output logic        erase_we,
  output logic [15:0] crc_next
);
  logic        mode_r;
  logic [23:0] cur, hi_r;
  logic [15:0] crc_r;

  assign addr     = cur;
  assign last     = busy && (cur == hi_r);
  assign erase_we = busy && !mode_r;
  assign crc_next = crc_word(crc_r, rdata);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      mode_r <= 1'b0;
      cur    <= '0;
      hi_r   <= '0;
      crc_r  <= CRC_SEED;
    end else if (start) begin
      busy   <= 1'b1;
      mode_r <= crc_mode;
      cur    <= lo;
      hi_r   <= hi;
      crc_r  <= CRC_SEED;
    end else if (busy) begin
      crc_r <= crc_next;
      if (cur == hi_r) busy <= 1'b0;
      else             cur  <= cur + 24'd1;
    end
  end

  // R6
  sweep_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last && !start) |=> (busy && (cur == $past(cur) + 24'd1)));

  // R7
  sweep_start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/fwu_cmd_engine.sv
module fwu_cmd_engine
  import fwu_pkg::*;
#(
  parameter int STORE_WORDS = 256,
  parameter int PAGE_WORDS  = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [63:0] in_data,
  input  logic [3:0]  in_len,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [63:0] out_data,
  output logic [3:0]  out_len,
  output logic        err_flag
);
  localparam logic [23:0] STORE_L   = 24'(STORE_WORDS);
  localparam logic [23:0] LAST_L    = 24'(STORE_WORDS - 1);
  localparam logic [23:0] PAGE_L    = 24'(PAGE_WORDS);
  localparam logic [23:0] PAGE_MASK = ~(PAGE_L - 24'd1);

  cmd_t        cmd;
  logic        take, good;
  logic [23:0] ptr;
  logic [23:0] rd_addr, rd_data;
  logic        sw_start, sw_crc, sw_busy, sw_last, sw_we;
  logic [23:0] sw_lo, sw_hi, sw_addr;
  logic [15:0] sw_crc_next;
  logic [23:0] er_lo, er_hi_raw, er_hi;
  logic        wa_en, wb_en;
  logic [23:0] wa_addr, wa_data, wb_addr;

  fwu_decode u_dec (.data(in_data), .len(in_len), .cmd(cmd));

  assign in_ready = !sw_busy && !out_valid;
  assign take     = in_valid && in_ready;
  assign good     = take && !cmd.bad;

  // erase bounds: whole pages, clipped to the implemented store
  assign er_lo     = cmd.fa & PAGE_MASK;
  assign er_hi_raw = (cmd.fb & PAGE_MASK) + (PAGE_L - 24'd1);
  assign er_hi     = ((cmd.fb >= STORE_L) || (er_hi_raw > LAST_L)) ? LAST_L : er_hi_raw;

  assign sw_crc   = (cmd.op == OP_CRC);
  assign sw_start = good && (sw_crc || ((cmd.op == OP_ERASE) && (er_lo < STORE_L)));
  assign sw_lo    = sw_crc ? cmd.fa : er_lo;
  assign sw_hi    = sw_crc ? cmd.fb : er_hi;

  fwu_sweep u_sweep (
    .clk(clk), .rst_n(rst_n), .start(sw_start), .crc_mode(sw_crc),
    .lo(sw_lo), .hi(sw_hi), .rdata(rd_data), .busy(sw_busy), .last(sw_last),
    .addr(sw_addr), .erase_we(sw_we), .crc_next(sw_crc_next)
  );

  // write port steering: sweep erase owns port A while it runs
  always_comb begin
    wa_en   = 1'b0;
    wa_addr = cmd.fa;
    wa_data = cmd.fb;
    wb_en   = 1'b0;
    wb_addr = ptr + 24'd1;
    if (sw_we) begin
      wa_en   = 1'b1;
      wa_addr = sw_addr;
      wa_data = ERASED_WORD;
    end else if (good && (cmd.op == OP_WRITE)) begin
      wa_en = 1'b1;
    end else if (good && (cmd.op == OP_STREAM)) begin
      wa_en   = 1'b1;
      wa_addr = ptr;
      wa_data = cmd.fa;
      wb_en   = 1'b1;
    end
  end

  assign rd_addr = sw_busy ? sw_addr : cmd.fa;

  fwu_store #(.DEPTH(STORE_WORDS)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wa_en(wa_en), .wa_addr(wa_addr), .wa_data(wa_data),
    .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(cmd.fb),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr       <= '0;
      err_flag  <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_len   <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (take && cmd.bad) err_flag <= 1'b1;
      if (good) begin
        case (cmd.op)
          OP_WRITE: begin
            ptr <= cmd.fa + 24'd1;
            if (cmd.fa >= STORE_L) err_flag <= 1'b1;
          end
          OP_STREAM: begin
            ptr <= ptr + 24'd2;
            if ((ptr >= STORE_L) || ((ptr + 24'd1) >= STORE_L)) err_flag <= 1'b1;
          end
          OP_READ: begin
            out_valid <= 1'b1;
            out_data  <= {MODE_READ, cmd.fa, rd_data, 8'h00};
            out_len   <= 4'd7;
          end
          default: ;
        endcase
      end
      if (sw_last && !sw_we) begin
        out_valid <= 1'b1;
        out_data  <= {MODE_CRC, sw_crc_next, 40'h0};
        out_len   <= 4'd3;
      end
    end
  end

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_len)));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  // R4
  ptr_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !cmd.bad && (cmd.op == OP_STREAM)) |=> (ptr == $past(ptr) + 24'd2));

  // R5
  reply_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> ($past(take) || $past(sw_last)));
endmodule

// File: tb/tb_fwu_cmd_engine.sv
module tb_fwu_cmd_engine;
  localparam int STORE = 256;
  localparam int PAGE  = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_data = '0;
  logic [3:0]  in_len = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] out_data;
  logic [3:0]  out_len;
  logic        err_flag;

  always #4 clk = ~clk;

  fwu_cmd_engine #(.STORE_WORDS(STORE), .PAGE_WORDS(PAGE)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_len(in_len), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_len(out_len), .err_flag(err_flag)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [23:0] ref_mem [STORE];
  logic [23:0] ref_ptr;
  bit          ref_err;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] ref_rd(input int a);
    return (a < STORE) ? ref_mem[a] : 24'hFFFFFF;
  endfunction

  function automatic logic [15:0] crc_ref(input int lo, input int hi);
    logic [15:0] c;
    logic [23:0] w;
    logic [7:0]  b;
    c = 16'hFFFF;
    for (int a = lo; a <= hi; a++) begin
      w = ref_rd(a);
      for (int k = 2; k >= 0; k--) begin
        b = w[k*8 +: 8];
        for (int i = 7; i >= 0; i--) begin
          if (c[15] ^ b[i]) c = {c[14:0], 1'b0} ^ 16'h1021;
          else              c = {c[14:0], 1'b0};
        end
      end
    end
    return c;
  endfunction

  task automatic send(input logic [7:0] m, input logic [23:0] a, input logic [23:0] b, input int len);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data  = {m, a, b, 8'h5A};
    in_len   = 4'(len);
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = '0;
  endtask

  task automatic take_reply;
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic do_write(input int a, input logic [23:0] d);
    send(8'hFF, 24'(a), d, 7);
    if (a < STORE) ref_mem[a] = d; else ref_err = 1'b1;
    ref_ptr = 24'(a) + 24'd1;
  endtask

  task automatic do_stream(input logic [23:0] d0, input logic [23:0] d1);
    send(8'hFE, d0, d1, 7);
    if (ref_ptr < 24'(STORE)) ref_mem[ref_ptr] = d0; else ref_err = 1'b1;
    if (ref_ptr + 24'd1 < 24'(STORE)) ref_mem[ref_ptr + 24'd1] = d1; else ref_err = 1'b1;
    ref_ptr = ref_ptr + 24'd2;
  endtask

  task automatic do_read(input int a, input string req);
    logic [63:0] exp;
    send(8'hFB, 24'(a), 24'h0, 4);
    exp = {8'hFB, 24'(a), ref_rd(a), 8'h00};
    check(out_valid === 1'b1 && out_len === 4'd7 && out_data === exp, req, out_data, exp);
    take_reply();
  endtask

  task automatic do_erase(input int s, input int e);
    int lo, hi, n, exp_n;
    send(8'hFC, 24'(s), 24'(e), 7);
    n = 0;
    while (!in_ready && n < 100000) begin n++; @(negedge clk); end
    lo = (s / PAGE) * PAGE;
    hi = (e / PAGE) * PAGE + PAGE - 1;
    if (hi > STORE - 1) hi = STORE - 1;
    exp_n = (lo < STORE) ? hi - lo + 1 : 0;
    for (int a = lo; a <= hi; a++) ref_mem[a] = 24'hFFFFFF;
    check(n == exp_n, "R6 erase busy cycles", 64'(n), 64'(exp_n));
  endtask

  task automatic do_crc(input int lo, input int hi);
    int n;
    logic [63:0] exp;
    send(8'hFD, 24'(lo), 24'(hi), 7);
    n = 0;
    while (!out_valid && n < 100000) begin n++; @(negedge clk); end
    exp = {8'hFD, crc_ref(lo, hi), 40'h0};
    check(n == hi - lo + 1, "R7 crc sweep cycles", 64'(n), 64'(hi - lo + 1));
    check(out_len === 4'd3 && out_data === exp, "R7 crc reply", out_data, exp);
    take_reply();
  endtask

  task automatic chk_err(input string req);
    check(err_flag === ref_err, req, 64'(err_flag), 64'(ref_err));
  endtask

  initial begin : main
    int unused_seed;
    unused_seed = $urandom(32'h00C0FFEE);
    for (int i = 0; i < STORE; i++) ref_mem[i] = 24'hFFFFFF;
    ref_ptr = '0;
    ref_err = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(in_ready === 1'b1, "R1 in_ready", 64'(in_ready), 64'd1);
    check(out_valid === 1'b0, "R1 out_valid", 64'(out_valid), 64'd0);
    check(err_flag === 1'b0, "R1 err_flag", 64'(err_flag), 64'd0);
    do_read(0, "R1 erased word after reset");
    do_stream(24'h111111, 24'h222222);   // R1 pointer starts at 0
    do_read(0, "R1 pointer zero at reset");
    do_read(1, "R4 second word of pair");

    // R2/R3 addressed write, byte order
    do_write(5, 24'hA1B2C3);
    do_read(5, "R3 addressed write R2 byte order");
    // R4 streaming continues from addr+1
    do_stream(24'h000001, 24'h000002);
    do_stream(24'h000003, 24'h000004);
    for (int a = 6; a <= 9; a++) do_read(a, "R4 stream placement");

    // R5 read outside store
    do_read(STORE + 10, "R5 out-of-store read");

    // R8 held reply under back-pressure
    send(8'hFB, 24'd5, 24'd0, 4);
    repeat (5) begin
      @(negedge clk);
      check(out_valid === 1'b1 && in_ready === 1'b0 &&
            out_data === {8'hFB, 24'd5, 24'hA1B2C3, 8'h00},
            "R8 reply held", out_data, {8'hFB, 24'd5, 24'hA1B2C3, 8'h00});
    end
    take_reply();
    check(out_valid === 1'b0 && in_ready === 1'b1, "R8 reply released", 64'(out_valid), 64'd0);

    // R7 crc over written data
    do_crc(0, 9);
    do_crc(5, 5);

    // R6 erase across a page boundary, off the top, and beyond
    for (int a = 60; a < 70; a++) do_write(a, 24'(a * 3 + 1));
    do_write(130, 24'h123456);
    do_erase(60, 70);
    do_read(127, "R6 erased page end");
    do_read(130, "R6 neighbour page kept");
    do_write(250, 24'h0F0F0F);
    do_erase(250, 300);
    do_read(250, "R6 top page erased");
    do_erase(300, 400);
    chk_err("R6 erase beyond store no error");

    // R9 bad frames
    send(8'h10, 24'd1, 24'd2, 7);
    check(out_valid === 1'b0 && in_ready === 1'b1, "R9 unknown mode no reply", 64'(out_valid), 64'd0);
    ref_err = 1'b1;
    chk_err("R9 unknown mode err");
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < STORE; i++) ref_mem[i] = 24'hFFFFFF;
    ref_ptr = '0;
    ref_err = 1'b0;
    chk_err("R1 err cleared by reset");
    do_write(20, 24'h777777);
    send(8'hFF, 24'd20, 24'h000000, 6);   // short frame
    ref_err = 1'b1;
    do_read(20, "R9 short frame dropped");
    chk_err("R9 short frame err");
    send(8'hFD, 24'd9, 24'd3, 7);          // end below start
    check(out_valid === 1'b0 && in_ready === 1'b1, "R9 reversed crc dropped", 64'(out_valid), 64'd0);
    send(8'hFC, 24'd25, 24'd20, 7);
    do_read(20, "R9 reversed erase dropped");
    do_stream(24'h313131, 24'h323232);
    do_read(21, "R9 pointer unchanged by bad frames");

    // R10 out-of-store write, pointer still moves
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < STORE; i++) ref_mem[i] = 24'hFFFFFF;
    ref_ptr = '0;
    ref_err = 1'b0;
    do_write(STORE - 2, 24'hABCDEF);
    chk_err("R10 in-range write no error");
    do_stream(24'h010101, 24'h020202);
    do_read(STORE - 1, "R10 in-range partner written");
    chk_err("R10 out-of-range stream err");
    do_write(STORE + 1, 24'h999999);
    do_stream(24'h030303, 24'h040404);
    do_read(0, "R10 wrap unaffected");

    // random mix
    for (int it = 0; it < 300; it++) begin
      int r, a, lo;
      r = int'($urandom % 10);
      a = int'($urandom % (STORE + 4));
      case (r)
        0, 1, 2: do_write(a, 24'($urandom));
        3, 4:    do_stream(24'($urandom), 24'($urandom));
        5, 6:    do_read(a, "R5 random read");
        7: begin
          if ($urandom % 2) send(8'(32'h20 + ($urandom % 8)), 24'(a), 24'd0, 7);
          else              send(8'hFE, 24'(a), 24'd0, int'($urandom % 7));
          ref_err = 1'b1;
        end
        8: begin
          lo = int'($urandom % STORE);
          do_crc(lo, lo + int'($urandom % 16));
        end
        default: begin
          lo = int'($urandom % STORE);
          do_erase(lo, lo + int'($urandom % 70));
        end
      endcase
      chk_err("R9 R10 random err flag");
    end

    for (int a = 0; a < STORE; a++) do_read(a, "R3 R4 R6 final contents");

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule